// File: doc/BRIEF.md
# Parallel NOR Page-Read Controller

This block sits on the host side of an asynchronous parallel NOR flash that offers page-mode reads. It accepts read requests on a valid/ready interface: a byte address and a flag that selects byte or word width. It drives the flash chip-enable, output-enable, write-enable, address bus and width-select pin, and returns the captured data with a one-cycle valid pulse. The flash powers up in read-array mode, so no command sequence comes before reading.

The controller remembers the page it last opened. A page is four words (eight bytes), named by the byte-address bits from bit 3 upward. A read is a page hit when it falls in that page, uses the same width, and chip-enable has stayed low since that page was opened. A hit waits `T_PAGE` clock cycles. Every other read waits `T_RAND` cycles. When no request arrives for `IDLE_TO` cycles after an access, chip-enable is released to save power, which also closes the page. In byte mode the top data pin becomes an output that carries the byte-address LSB, and only the low data byte is returned.

Top module: `nor_page_rd`

## Requirements
- R1: After reset, chip-enable, output-enable and write-enable are high (inactive), req_ready_o is 1 and rsp_valid_o is 0. No page is open after reset, so the first read takes T_RAND cycles even if it targets the page that was open before the reset.
- R2: Output-enable is low exactly while an access is in progress, and chip-enable is low whenever output-enable is low. Write-enable stays high at all times.
- R3: A read that misses the open page, or arrives when no page is open, raises rsp_valid_o T_RAND clock edges after the edge that accepted it (default 7).
- R4: A read whose byte-address bits [ADDR_W:3] equal those of the open page, with the same width flag and chip-enable held low since that page opened, raises rsp_valid_o T_PAGE edges after acceptance (default 2).
- R5: A change of the width flag from the previous read makes the read a miss (T_RAND), even within the same page.
- R6: When IDLE_TO cycles (default 16) pass after the end of an access with no request accepted, chip-enable goes high and the page closes. A request accepted on the IDLE_TO-th idle edge or earlier is still a hit.
- R7: Word mode (req_byte_i=0): fl_word_sel_o=1, fl_addr_o = req_addr_i[ADDR_W:1], fl_dq15_oe_o=0, and rsp_data_o returns all 16 bits of fl_dq_i.
- R8: Byte mode (req_byte_i=1): fl_word_sel_o=0, fl_dq15_oe_o=1 during the access with fl_dq15_o = req_addr_i[0], and rsp_data_o = {8'h00, fl_dq_i[7:0]}.
- R9: Data is sampled from fl_dq_i on the last cycle of the access. rsp_valid_o is high for exactly one cycle. req_ready_o is 0 while an access is in progress and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_addr_i | input | ADDR_W+1 | Byte address of the read |
| req_byte_i | input | 1 | 1 = byte read, 0 = word read |
| rsp_valid_o | output | 1 | One-cycle pulse: rsp_data_o valid |
| rsp_data_o | output | 16 | Read data |
| fl_ce_no | output | 1 | Flash chip-enable, active low |
| fl_oe_no | output | 1 | Flash output-enable, active low |
| fl_we_no | output | 1 | Flash write-enable, held high |
| fl_word_sel_o | output | 1 | Width select: 1 = 16-bit, 0 = 8-bit |
| fl_addr_o | output | ADDR_W | Flash word address |
| fl_dq_i | input | 16 | Flash data bus |
| fl_dq15_o | output | 1 | Byte-address LSB for the top data pin in byte mode |
| fl_dq15_oe_o | output | 1 | Drive enable for fl_dq15_o |

## Verification
Each result is due a fixed number of clock edges after the edge that accepts the request: T_PAGE for a page hit, T_RAND for any other read. The bench counts edges from acceptance, samples at falling edges, and requires the first valid pulse at exactly that count. The pulse must drop on the next edge. Pin levels are checked on the first falling edge after acceptance. The chip-enable release is checked after idle gaps that sit one cycle on each side of the timeout. A gap of 14 idle falling edges must still give a hit, and a gap of 15 must show chip-enable high and give a miss.

// File: rtl/nor_rd_pkg.sv
package nor_rd_pkg;
  localparam int unsigned DQ_W     = 16;
  localparam int unsigned PAGE_LSB = 3;  // byte-address bit that starts the page tag

  function automatic logic [DQ_W-1:0] lane_sel(input logic byte_m, input logic [DQ_W-1:0] dq);
    return byte_m ? {{(DQ_W-8){1'b0}}, dq[7:0]} : dq;
  endfunction
endpackage

// File: rtl/nor_acc_timer.sv
module nor_acc_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             busy_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CNT_W'(1));

  // R9
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/nor_page_trk.sv
module nor_page_trk #(
  parameter int unsigned TAG_W   = 20,
  parameter int unsigned IDLE_TO = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             busy_i,
  input  logic [TAG_W-1:0] page_i,
  input  logic             byte_i,
  output logic             hit_o,
  output logic             open_o
);
  localparam int unsigned IDLE_W = $clog2(IDLE_TO + 1);

  logic             open_q;
  logic [TAG_W-1:0] tag_q;
  logic             byte_q;
  logic [IDLE_W-1:0] idle_q;
  logic             expire;

  assign expire = open_q && !busy_i && (idle_q == IDLE_W'(IDLE_TO - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      tag_q  <= '0;
      byte_q <= 1'b0;
    end else if (start_i) begin
      open_q <= 1'b1;
      tag_q  <= page_i;
      byte_q <= byte_i;
    end else if (expire) begin
      open_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                idle_q <= '0;
    else if (start_i || busy_i || !open_q || expire) idle_q <= '0;
    else                                        idle_q <= idle_q + 1'b1;
  end

  // chip-enable held low is implied by open_q
  assign hit_o  = open_q && (tag_q == page_i) && (byte_q == byte_i);
  assign open_o = open_q;
endmodule

// File: rtl/nor_page_rd.sv
module nor_page_rd #(
  parameter int unsigned ADDR_W  = 22,
  parameter int unsigned T_RAND  = 7,
  parameter int unsigned T_PAGE  = 2,
  parameter int unsigned IDLE_TO = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W:0]   req_addr_i,
  input  logic              req_byte_i,
  output logic              rsp_valid_o,
  output logic [15:0]       rsp_data_o,
  output logic              fl_ce_no,
  output logic              fl_oe_no,
  output logic              fl_we_no,
  output logic              fl_word_sel_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  input  logic [15:0]       fl_dq_i,
  output logic              fl_dq15_o,
  output logic              fl_dq15_oe_o
);
  import nor_rd_pkg::*;

  localparam int unsigned CNT_W = $clog2(T_RAND + 1);
  localparam int unsigned TAG_W = ADDR_W + 1 - PAGE_LSB;
  localparam logic [CNT_W-1:0] LEN_RAND = CNT_W'(T_RAND);
  localparam logic [CNT_W-1:0] LEN_PAGE = CNT_W'(T_PAGE);

  logic            busy, last, hit, open, accept;
  logic [ADDR_W:0] addr_q;
  logic            byte_q;
  logic            rsp_v_q;
  logic [15:0]     rsp_d_q;

  assign accept = req_valid_i && !busy;

  nor_acc_timer #(.CNT_W(CNT_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .len_i  (hit ? LEN_PAGE : LEN_RAND),
    .busy_o (busy),
    .last_o (last)
  );

  nor_page_trk #(.TAG_W(TAG_W), .IDLE_TO(IDLE_TO)) i_trk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .busy_i  (busy),
    .page_i  (req_addr_i[ADDR_W:PAGE_LSB]),
    .byte_i  (req_byte_i),
    .hit_o   (hit),
    .open_o  (open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      byte_q <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr_i;
      byte_q <= req_byte_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= last;
      if (last) rsp_d_q <= lane_sel(byte_q, fl_dq_i);
    end
  end

  assign req_ready_o   = !busy;
  assign rsp_valid_o   = rsp_v_q;
  assign rsp_data_o    = rsp_d_q;
  assign fl_ce_no      = !open;
  assign fl_oe_no      = !busy;
  assign fl_we_no      = 1'b1;
  assign fl_word_sel_o = !byte_q;
  assign fl_addr_o     = addr_q[ADDR_W:1];
  assign fl_dq15_o     = addr_q[0];
  assign fl_dq15_oe_o  = byte_q && busy;

  // R2
  oe_needs_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> !fl_ce_no);
  // R9
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R9
  rsp_after_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!fl_oe_no));
  // R6
  ce_rel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fl_ce_no) |-> $past(fl_oe_no));
endmodule

// File: tb/test_nor_page_rd.sv
`timescale 1ns/1ps
module test_nor_page_rd;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [22:0] req_addr = '0;
  logic        req_byte = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        ce_n, oe_n, we_n, word_sel, dq15, dq15_oe;
  logic [21:0] fl_addr;
  logic [15:0] dq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] mdl(input logic [21:0] wa);
    return (wa[15:0] * 16'd3 + {10'h0, wa[21:16]}) ^ 16'h5A3C;
  endfunction

  assign dq = word_sel ? mdl(fl_addr)
                       : {8'hFF, (dq15 ? mdl(fl_addr)[15:8] : mdl(fl_addr)[7:0])};

  nor_page_rd i_nor_page_rd (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_byte_i(req_byte),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .fl_ce_no(ce_n), .fl_oe_no(oe_n), .fl_we_no(we_n),
    .fl_word_sel_o(word_sel), .fl_addr_o(fl_addr), .fl_dq_i(dq),
    .fl_dq15_o(dq15), .fl_dq15_oe_o(dq15_oe)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [22:0] a, input logic bm, input int lat, input string rq);
    int k;
    logic [15:0] w, exp_d;
    req_valid = 1'b1; req_addr = a; req_byte = bm;
    @(posedge clk); #1; req_valid = 1'b0;
    @(negedge clk);
    chk(!oe_n && !ce_n && we_n, "R2", "pins during access", {oe_n, ce_n, we_n}, 3'b001);
    chk(!req_ready, "R9", "ready while busy", req_ready, 0);
    chk(fl_addr == a[22:1], bm ? "R8" : "R7", "flash address", fl_addr, a[22:1]);
    chk(word_sel == !bm && dq15_oe == bm, bm ? "R8" : "R7", "width pins",
        {word_sel, dq15_oe}, {!bm, bm});
    if (bm) chk(dq15 == a[0], "R8", "dq15 address bit", dq15, a[0]);
    k = 0;
    while (!rsp_valid && k < 40) begin
      @(negedge clk); k++;
    end
    chk(k == lat, rq, "latency", k, lat);
    w = mdl(a[22:1]);
    exp_d = bm ? {8'h00, (a[0] ? w[15:8] : w[7:0])} : w;
    chk(rsp_data == exp_d, bm ? "R8" : "R7", "read data", rsp_data, exp_d);
    @(negedge clk);
    chk(!rsp_valid && req_ready && oe_n, "R9", "pulse end / idle",
        {rsp_valid, req_ready, oe_n}, 3'b011);
  endtask

  typedef struct packed {
    logic [22:0] a;
    logic        bm;
    logic [7:0]  gap;
    logic [7:0]  lat;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{23'h000100, 1'b0, 8'd0,  8'd7},  // R3 closed page
    '{23'h000102, 1'b0, 8'd0,  8'd2},  // R4
    '{23'h000106, 1'b0, 8'd2,  8'd2},  // R4
    '{23'h000108, 1'b0, 8'd0,  8'd7},  // R3 next page
    '{23'h00010B, 1'b1, 8'd0,  8'd7},  // R5 to byte
    '{23'h00010C, 1'b1, 8'd0,  8'd2},  // R4 byte hit
    '{23'h00010A, 1'b0, 8'd0,  8'd7},  // R5 to word
    '{23'h00010E, 1'b0, 8'd14, 8'd2},  // R6 just before timeout
    '{23'h00010C, 1'b0, 8'd15, 8'd7},  // R6 timed out
    '{23'h7FFFF8, 1'b0, 8'd0,  8'd7},  // R3 top page
    '{23'h7FFFFF, 1'b1, 8'd0,  8'd7},  // R5
    '{23'h7FFFF9, 1'b1, 8'd0,  8'd2}   // R4
  };

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ce_n && oe_n && we_n, "R1", "flash pins in reset", {ce_n, oe_n, we_n}, 3'b111);
    chk(req_ready && !rsp_valid, "R1", "handshake in reset", {req_ready, rsp_valid}, 2'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && oe_n && we_n && req_ready && !rsp_valid, "R1", "after reset release",
        {ce_n, oe_n, we_n, req_ready, rsp_valid}, 5'b11110);

    foreach (VECS[i]) begin
      if (VECS[i].gap != 0) begin
        repeat (int'(VECS[i].gap)) @(negedge clk);
        chk(ce_n == (VECS[i].gap >= 15), "R6", "chip-enable after idle gap",
            ce_n, VECS[i].gap >= 15);
      end
      do_read(VECS[i].a, VECS[i].bm, int'(VECS[i].lat),
              VECS[i].lat == 8'd2 ? "R4" : (i == 4 || i == 6 || i == 10) ? "R5" : "R3");
    end

    // R1: reset closes the open page
    do_read(23'h000200, 1'b0, 7, "R3");
    do_read(23'h000202, 1'b0, 2, "R4");
    rst_n = 1'b0;
    @(negedge clk);
    chk(ce_n && oe_n && req_ready, "R1", "reset mid-page", {ce_n, oe_n, req_ready}, 3'b111);
    rst_n = 1'b1;
    @(negedge clk);
    do_read(23'h000204, 1'b0, 7, "R1");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule